// File: doc/BRIEF.md
# Video capture event and interrupt controller

This block keeps the event flags of a video capture unit and merges them onto one level-sensitive interrupt request. Three sticky events are tracked: an image has been captured completely (all internal buffers flushed to memory), the line counter has reached a programmed line number, and an internal buffer overflowed because memory bandwidth ran short. Each flag stays set until software writes a 1 to its acknowledge bit in a control write. The same control write also loads a capture-enable bit and one interrupt-enable bit per event.

Acknowledging the capture-complete event does two things: it clears the flag, and it issues a one-cycle start pulse that tells the capture datapath to take the next image. The line-threshold event is independent of the capture-enable bit. Software can therefore use it to count off fields while no capture is running. The block also keeps a field-parity bit, which it loads only at the start of vertical blanking. The interrupt handler reads the status word to find which events are pending.

Top module: `vcap_evt_ctrl`

## Requirements
- R1: After reset the status word, `irq_o` and `cap_start_o` are all 0.
- R2: A `cap_done_i` pulse sets status bit 0 (capture complete) on the next clock edge, but only while status bit 4 (capture enable) is 1. While capture enable is 0, the pulse leaves bit 0 unchanged.
- R3: A control write with `ctl_ack_i[0]`=1 clears status bit 0 on that edge and raises `cap_start_o` for exactly the following cycle. `cap_start_o` is 0 in every other cycle.
- R4: Status bit 1 (threshold reached) is set on the edge after `line_cur_i` changes to a value equal to `line_thr_i`. It is not set again while `line_cur_i` holds that value, and it works whether capture enable is 0 or 1.
- R5: An `ovf_i` pulse sets status bit 2 (bandwidth error), which stays set until a control write with `ctl_ack_i[2]`=1.
- R6: An acknowledge bit written as 0 leaves its flag unchanged. When an event and the acknowledge of the same flag come in the same cycle, the flag ends up set.
- R7: `irq_o` is 1 exactly when some flag is set whose enable bit is 1 (enable bit i in `ctl_ie_i[i]` pairs with status bit i). A flag whose enable bit is 0 stays visible in the status word but does not drive `irq_o`.
- R8: `irq_o` falls on the same clock edge that clears the last pending enabled flag.
- R9: Status bit 3 (field 2) takes the value of `field_odd_i` on an edge where `vblank_start_i` is 1, and holds its value on every other edge.
- R10: A control write loads status bit 4 from `ctl_cap_en_i` and the interrupt enables from `ctl_ie_i`. The new values take effect from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_done_i | input | 1 | Pulse: image fully flushed to memory |
| line_cur_i | input | LINE_W | Current line number |
| line_thr_i | input | LINE_W | Programmed line threshold |
| ovf_i | input | 1 | Pulse: internal buffer overflow |
| field_odd_i | input | 1 | Field parity, 1 = second field |
| vblank_start_i | input | 1 | Pulse: start of vertical blanking |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_cap_en_i | input | 1 | Capture-enable value carried by the write |
| ctl_ie_i | input | 3 | Interrupt enables; bit 0 capture done, bit 1 threshold, bit 2 bandwidth error |
| ctl_ack_i | input | 3 | Acknowledge bits, same bit order as the enables |
| status_o | output | 5 | {capture enable, field 2, bandwidth error, threshold, capture complete} |
| irq_o | output | 1 | Level interrupt request |
| cap_start_o | output | 1 | One-cycle pulse: capture the next image |

## Verification
The capture-done pulse is sent once with capture disabled and once with it enabled, which separates a flag that checks the enable bit from one that does not. For the threshold, the line counter steps onto the threshold, stays there across an acknowledge, then leaves and comes back, and finally arrives in the same cycle as an acknowledge. This tells apart an edge-triggered compare, a level compare, and the wrong choice between set and clear. The interrupt is checked with the flag set but masked, and with two enabled flags acknowledged one at a time, so that the bench can tell a masked flag from a missing flag and see that the request falls only when the last flag clears. The field bit gets parity changes both with and without the blanking pulse.

// File: rtl/vcap_evt_pkg.sv
package vcap_evt_pkg;
    localparam int NUM_EVT = 3;
    localparam int EV_CC   = 0;
    localparam int EV_THR  = 1;
    localparam int EV_BWE  = 2;
    localparam int ST_FLD  = NUM_EVT;
    localparam int ST_CEN  = NUM_EVT + 1;
    localparam int STAT_W  = NUM_EVT + 2;
endpackage

// File: rtl/vcap_thr_detect.sv
module vcap_thr_detect #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_cur_i,
    input  logic [LINE_W-1:0] line_thr_i,
    output logic              hit_o
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] prev;
    } thr_state_t;

    thr_state_t st_d, st_q;
    logic       line_moved;

    always_comb begin
        st_d       = st_q;
        line_moved = !st_q.vld || (line_cur_i != st_q.prev);
        hit_o      = line_moved && (line_cur_i == line_thr_i);
        st_d.vld   = 1'b1;
        st_d.prev  = line_cur_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vcap_sticky_flags.sv
module vcap_sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] flag_nxt_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } flg_state_t;

    flg_state_t   st_d, st_q;
    logic [N-1:0] bit_nxt;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // set has priority over clear
        assign bit_nxt[i] = set_i[i] | (st_q.flag[i] & ~clr_i[i]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = bit_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o     = st_q.flag;
    assign flag_nxt_o = st_d.flag;
endmodule

// File: rtl/vcap_field_track.sv
module vcap_field_track (
    input  logic clk,
    input  logic rst_n,
    input  logic field_odd_i,
    input  logic vblank_start_i,
    output logic field2_o
);
    typedef struct packed {
        logic fld;
    } fld_state_t;

    fld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vblank_start_i) st_d.fld = field_odd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign field2_o = st_q.fld;
endmodule

// File: rtl/vcap_evt_ctrl.sv
module vcap_evt_ctrl
    import vcap_evt_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_done_i,
    input  logic [LINE_W-1:0] line_cur_i,
    input  logic [LINE_W-1:0] line_thr_i,
    input  logic              ovf_i,
    input  logic              field_odd_i,
    input  logic              vblank_start_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_cap_en_i,
    input  logic [NUM_EVT-1:0] ctl_ie_i,
    input  logic [NUM_EVT-1:0] ctl_ack_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o,
    output logic              cap_start_o
);
    typedef struct packed {
        logic               cap_en;
        logic [NUM_EVT-1:0] ie;
        logic               start;
        logic               irq;
    } top_state_t;

    top_state_t         st_d, st_q;
    logic               thr_hit;
    logic               field2;
    logic [NUM_EVT-1:0] ev_set;
    logic [NUM_EVT-1:0] ev_clr;
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] flags_nxt;

    vcap_thr_detect #(.LINE_W(LINE_W)) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_cur_i (line_cur_i),
        .line_thr_i (line_thr_i),
        .hit_o      (thr_hit)
    );

    vcap_sticky_flags #(.N(NUM_EVT)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ev_set),
        .clr_i      (ev_clr),
        .flag_o     (flags),
        .flag_nxt_o (flags_nxt)
    );

    vcap_field_track u_fld (
        .clk            (clk),
        .rst_n          (rst_n),
        .field_odd_i    (field_odd_i),
        .vblank_start_i (vblank_start_i),
        .field2_o       (field2)
    );

    always_comb begin
        ev_set         = '0;
        ev_set[EV_CC]  = cap_done_i & st_q.cap_en;
        ev_set[EV_THR] = thr_hit;
        ev_set[EV_BWE] = ovf_i;
        ev_clr         = ctl_wr_i ? ctl_ack_i : '0;
    end

    always_comb begin
        st_d = st_q;
        if (ctl_wr_i) begin
            st_d.cap_en = ctl_cap_en_i;
            st_d.ie     = ctl_ie_i;
        end
        st_d.start = ctl_wr_i & ctl_ack_i[EV_CC];
        st_d.irq   = |(flags_nxt & st_d.ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o                = '0;
        status_o[NUM_EVT-1:0]   = flags;
        status_o[ST_FLD]        = field2;
        status_o[ST_CEN]        = st_q.cap_en;
    end

    assign irq_o       = st_q.irq;
    assign cap_start_o = st_q.start;
endmodule

// File: rtl/vcap_evt_chk.sv
module vcap_evt_chk
    import vcap_evt_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_done_i,
    input logic [LINE_W-1:0] line_cur_i,
    input logic [LINE_W-1:0] line_thr_i,
    input logic              ovf_i,
    input logic              field_odd_i,
    input logic              vblank_start_i,
    input logic              ctl_wr_i,
    input logic [NUM_EVT-1:0] ctl_ie_i,
    input logic [NUM_EVT-1:0] ctl_ack_i,
    input logic [STAT_W-1:0] status_o,
    input logic              irq_o,
    input logic              cap_start_o
);
    p_cc_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done_i && status_o[ST_CEN] |=> status_o[EV_CC]);

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i && ctl_ack_i[EV_CC] |=> cap_start_o && !status_o[EV_CC] || cap_start_o);

    p_start_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr_i && ctl_ack_i[EV_CC]) |=> !cap_start_o);

    p_bwe_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> status_o[EV_BWE]);

    p_bwe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[EV_BWE] && !(ctl_wr_i && ctl_ack_i[EV_BWE]) |=> status_o[EV_BWE]);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i && (ctl_ie_i == '0) |=> !irq_o);

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i && (ctl_ack_i == '1) && !cap_done_i && !ovf_i
        && (line_cur_i != line_thr_i) |=> !irq_o);

    p_field_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank_start_i |=> $stable(status_o[ST_FLD]));

    p_field_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start_i |=> status_o[ST_FLD] == $past(field_odd_i));
endmodule

bind vcap_evt_ctrl vcap_evt_chk #(.LINE_W(LINE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cap_done_i     (cap_done_i),
    .line_cur_i     (line_cur_i),
    .line_thr_i     (line_thr_i),
    .ovf_i          (ovf_i),
    .field_odd_i    (field_odd_i),
    .vblank_start_i (vblank_start_i),
    .ctl_wr_i       (ctl_wr_i),
    .ctl_ie_i       (ctl_ie_i),
    .ctl_ack_i      (ctl_ack_i),
    .status_o       (status_o),
    .irq_o          (irq_o),
    .cap_start_o    (cap_start_o)
);

// File: tb/sim_vcap_evt_ctrl.sv
module sim_vcap_evt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cap_done_i = 1'b0;
    logic [LINE_W-1:0] line_cur_i = '0;
    logic [LINE_W-1:0] line_thr_i = 11'd100;
    logic              ovf_i = 1'b0;
    logic              field_odd_i = 1'b0;
    logic              vblank_start_i = 1'b0;
    logic              ctl_wr_i = 1'b0;
    logic              ctl_cap_en_i = 1'b0;
    logic [2:0]        ctl_ie_i = '0;
    logic [2:0]        ctl_ack_i = '0;
    logic [4:0]        status_o;
    logic              irq_o;
    logic              cap_start_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcap_evt_ctrl #(.LINE_W(LINE_W)) u0 (
        .clk (clk), .rst_n (rst_n), .cap_done_i (cap_done_i),
        .line_cur_i (line_cur_i), .line_thr_i (line_thr_i), .ovf_i (ovf_i),
        .field_odd_i (field_odd_i), .vblank_start_i (vblank_start_i),
        .ctl_wr_i (ctl_wr_i), .ctl_cap_en_i (ctl_cap_en_i),
        .ctl_ie_i (ctl_ie_i), .ctl_ack_i (ctl_ack_i),
        .status_o (status_o), .irq_o (irq_o), .cap_start_o (cap_start_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock edge; returns at the following falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    // control write held for one edge; other inputs left as the caller set them
    task automatic wr(input logic cen, input logic [2:0] ie, input logic [2:0] ack);
        ctl_wr_i = 1'b1; ctl_cap_en_i = cen; ctl_ie_i = ie; ctl_ack_i = ack;
        tick();
        ctl_wr_i = 1'b0; ctl_ack_i = '0;
    endtask

    task automatic t_reset();
        chk("R1 status", int'(status_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 cap_start", int'(cap_start_o), 0);
    endtask

    task automatic t_capture();
        cap_done_i = 1'b1; tick(); cap_done_i = 1'b0;
        chk("R2 done ignored while disabled", int'(status_o[0]), 0);
        wr(1'b1, 3'b000, 3'b000);
        chk("R10 capture enable loaded", int'(status_o[4]), 1);
        cap_done_i = 1'b1; tick(); cap_done_i = 1'b0;
        chk("R2 done sets flag", int'(status_o[0]), 1);
        chk("R7 masked flag no irq", int'(irq_o), 0);
        wr(1'b1, 3'b001, 3'b000);
        chk("R7 enabled flag irq", int'(irq_o), 1);
        chk("R6 zero ack keeps flag", int'(status_o[0]), 1);
        chk("R3 no start without ack", int'(cap_start_o), 0);
        wr(1'b1, 3'b001, 3'b001);
        chk("R3 ack clears flag", int'(status_o[0]), 0);
        chk("R8 irq drops with last flag", int'(irq_o), 0);
        chk("R3 start pulse", int'(cap_start_o), 1);
        tick();
        chk("R3 start one cycle", int'(cap_start_o), 0);
    endtask

    task automatic t_thresh();
        wr(1'b0, 3'b010, 3'b000);
        chk("R10 capture disabled", int'(status_o[4]), 0);
        line_cur_i = 11'd100; tick();
        chk("R4 threshold sets while capture off", int'(status_o[1]), 1);
        chk("R7 threshold irq", int'(irq_o), 1);
        wr(1'b0, 3'b010, 3'b010);
        chk("R4 ack clears threshold", int'(status_o[1]), 0);
        tick(); tick();
        chk("R4 no refire while line holds", int'(status_o[1]), 0);
        line_cur_i = 11'd101; tick();
        chk("R4 no set off threshold", int'(status_o[1]), 0);
        line_cur_i = 11'd100; tick();
        chk("R4 set on return", int'(status_o[1]), 1);
        wr(1'b0, 3'b010, 3'b010);
        line_cur_i = 11'd99; tick();
        line_cur_i = 11'd100;
        wr(1'b0, 3'b010, 3'b010);
        chk("R6 set wins over ack (threshold)", int'(status_o[1]), 1);
        wr(1'b0, 3'b010, 3'b010);
        chk("R4 cleared", int'(status_o[1]), 0);
    endtask

    task automatic t_bwe();
        ovf_i = 1'b1; tick(); ovf_i = 1'b0;
        chk("R5 overflow sets flag", int'(status_o[2]), 1);
        tick(); tick(); tick();
        chk("R5 flag sticky", int'(status_o[2]), 1);
        wr(1'b0, 3'b000, 3'b011);
        chk("R6 other acks leave flag", int'(status_o[2]), 1);
        wr(1'b0, 3'b000, 3'b100);
        chk("R5 ack clears flag", int'(status_o[2]), 0);
        ovf_i = 1'b1;
        wr(1'b0, 3'b000, 3'b100);
        ovf_i = 1'b0;
        chk("R6 set wins over ack (overflow)", int'(status_o[2]), 1);
        wr(1'b0, 3'b000, 3'b100);
    endtask

    task automatic t_irq();
        wr(1'b1, 3'b111, 3'b000);
        cap_done_i = 1'b1; ovf_i = 1'b1; tick();
        cap_done_i = 1'b0; ovf_i = 1'b0;
        chk("R7 two flags irq", int'(irq_o), 1);
        wr(1'b1, 3'b111, 3'b001);
        chk("R8 irq held while one pending", int'(irq_o), 1);
        wr(1'b1, 3'b111, 3'b100);
        chk("R8 irq drops after last ack", int'(irq_o), 0);
        ovf_i = 1'b1; tick(); ovf_i = 1'b0;
        wr(1'b1, 3'b011, 3'b000);
        chk("R7 disable masks irq", int'(irq_o), 0);
        chk("R7 masked flag visible", int'(status_o[2]), 1);
        wr(1'b1, 3'b111, 3'b100);
    endtask

    task automatic t_field();
        field_odd_i = 1'b1; tick();
        chk("R9 no load without blank", int'(status_o[3]), 0);
        vblank_start_i = 1'b1; tick(); vblank_start_i = 1'b0;
        chk("R9 load at blank", int'(status_o[3]), 1);
        field_odd_i = 1'b0; tick(); tick();
        chk("R9 hold between blanks", int'(status_o[3]), 1);
        vblank_start_i = 1'b1; tick(); vblank_start_i = 1'b0;
        chk("R9 load zero at blank", int'(status_o[3]), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_capture();
        t_thresh();
        t_bwe();
        t_irq();
        t_field();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule